// File: doc/BRIEF.md
# Multi-Channel Staggered PWM Dimmer

This block turns one 8-bit brightness value into on/off gate signals for eight LED current-sink channels. It also drives a DC level code for a current DAC that sits outside the block. A phase counter advances once per `step_tick`, so one dimming period lasts 256 ticks. The tick source sets the dimming frequency, which is normally between 200 Hz and 10 kHz.

Within each period, the block can place the channel pulses in several ways:
- every channel switches at the same instants;
- each channel lags the one before it by a fixed two steps;
- the lags are spread evenly over the active channels;
- every channel follows an external PWM input directly;
- every channel stays on, and the brightness value goes out as an analog current level.

The brightness value, the mode and the active-channel count are sampled only when the period wraps. A setting change therefore takes effect at the start of the next period.

Top module: `stagger_dimmer`

## Requirements
- R1: While `rst` is high, and on the first edge after it, every gate is 0 and `dc_level` is 255. The phase counter restarts at 0, and the latched setting becomes mode 0 with duty 0 and count 0.
- R2: Each `step_tick` advances the phase by one, modulo 256. `duty`, `mode` and `lane_count` are copied into the latched setting only on an edge where `step_tick` is high and the phase is 255. A change at any other time has no effect until that edge.
- R3: Mode code 0 (together). Every active gate is high exactly when phase < duty. A gate registers on the edge after the phase value it reflects.
- R4: In the pulse modes (codes 0, 1 and 2), duty 0 keeps the gate low for the whole period. Duty 255 keeps it high for the whole period, with no gap.
- R5: Mode code 1 (fixed step). Channel k, counted from 0, is high when ((phase − 2k) mod 256) < duty. A lagged pulse therefore wraps into the next period at full width.
- R6: Mode code 2 (spread). Channel k uses the offset floor(256·k/N), where N is the latched active count, with the same wrap rule as R5.
- R7: Mode code 3 (direct). Every active gate copies `pwm_in` after a two-flop synchronizer and the output register, which is 3 clock edges of latency, with no per-channel lag.
- R8: Mode code 4 (level). Every active gate is held high and `dc_level` equals the latched duty. In every other mode, `dc_level` is 255.
- R9: Only channels 0 to N−1 can be high, where N is the latched count. A count above 8 acts as 8, and a count of 0 keeps every channel low.
- R10: Mode codes 5, 6 and 7 keep every gate low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_tick | input | 1 | Advances the dimming phase by one step |
| duty | input | 8 | Brightness value, 0 to 255 |
| mode | input | 3 | Timing mode code (0 together, 1 fixed step, 2 spread, 3 direct, 4 level) |
| lane_count | input | 4 | Number of active channels, starting from channel 0 |
| pwm_in | input | 1 | External PWM input, asynchronous |
| gate | output | 8 | Per-channel enable for the current sinks |
| dc_level | output | 8 | Level code for the external current DAC |

## Verification
The bench runs each timing mode with mid-range, near-full and extreme duty values.

- A duty of 250 in fixed-step mode separates correct modulo wrap of the lagged pulses from truncation at the period end.
- Spread mode is tried with 8, 5 and 3 channels, and with a slower tick. Non-power-of-two counts show whether the floor division of the offsets is right.
- Counts of 0, 4 and 12 show whether the channels are allocated in order and whether the count is clipped.
- Settings are changed partway through a period, which shows whether they are sampled only at the wrap.
- A toggling `pwm_in` pattern, whose period is unrelated to the dimming period, exposes any latency or gating error in direct mode.

// File: rtl/dim_pkg.sv
package dim_pkg;
  localparam logic [2:0] MODE_SYNC   = 3'd0;
  localparam logic [2:0] MODE_FIXED  = 3'd1;
  localparam logic [2:0] MODE_SPREAD = 3'd2;
  localparam logic [2:0] MODE_DIRECT = 3'd3;
  localparam logic [2:0] MODE_LEVEL  = 3'd4;

  function automatic logic is_pulse_mode(input logic [2:0] m);
    return (m == MODE_SYNC) || (m == MODE_FIXED) || (m == MODE_SPREAD);
  endfunction
endpackage

// File: rtl/dim_phase_ctr.sv
module dim_phase_ctr #(
  parameter int PH_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_tick,
  output logic [PH_W-1:0] phase,
  output logic            wrap
);
  assign wrap = step_tick && (phase == '1);

  always_ff @(posedge clk) begin
    if (rst)            phase <= '0;
    else if (step_tick) phase <= phase + 1'b1;
  end
endmodule

// File: rtl/dim_sync.sv
module dim_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/dim_shadow.sv
module dim_shadow
  import dim_pkg::*;
#(
  parameter int CHANNELS   = 8,
  parameter int PH_W       = 8,
  parameter int CNT_W      = 4,
  parameter int FIXED_STEP = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load,
  input  logic [PH_W-1:0]                duty_in,
  input  logic [2:0]                     mode_in,
  input  logic [CNT_W-1:0]               count_in,
  output logic [PH_W-1:0]                duty_q,
  output logic [2:0]                     mode_q,
  output logic [CNT_W-1:0]               cnt_q,
  output logic [CHANNELS-1:0][PH_W-1:0]  offsets,
  output logic [PH_W-1:0]                dc_level
);
  localparam int STEPS = 1 << PH_W;

  logic [CNT_W-1:0]              cnt_clip;
  logic [CHANNELS-1:0][PH_W-1:0] off_next;

  assign cnt_clip = (count_in > CNT_W'(CHANNELS)) ? CNT_W'(CHANNELS) : count_in;

  generate
    for (genvar g = 0; g < CHANNELS; g++) begin : g_off
      always_comb begin
        case (mode_in)
          MODE_FIXED:  off_next[g] = PH_W'(FIXED_STEP * g);
          MODE_SPREAD: off_next[g] = (cnt_clip == '0) ? '0
                                     : PH_W'((STEPS * g) / int'(cnt_clip));
          default:     off_next[g] = '0;
        endcase
      end

      always_ff @(posedge clk) begin
        if (rst)       offsets[g] <= '0;
        else if (load) offsets[g] <= off_next[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q   <= '0;
      mode_q   <= MODE_SYNC;
      cnt_q    <= '0;
      dc_level <= '1;
    end else if (load) begin
      duty_q   <= duty_in;
      mode_q   <= mode_in;
      cnt_q    <= cnt_clip;
      dc_level <= (mode_in == MODE_LEVEL) ? duty_in : '1;
    end
  end
endmodule

// File: rtl/dim_lane.sv
module dim_lane
  import dim_pkg::*;
#(
  parameter int PH_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] phase,
  input  logic [PH_W-1:0] offset,
  input  logic [PH_W-1:0] duty,
  input  logic [2:0]      mode,
  input  logic            lane_en,
  input  logic            pwm_s,
  output logic            gate
);
  logic [PH_W-1:0] rel;
  logic            pulse_on;
  logic            sel;

  assign rel      = phase - offset;
  assign pulse_on = (duty == '1) || (rel < duty);

  always_comb begin
    case (mode)
      MODE_SYNC, MODE_FIXED, MODE_SPREAD: sel = pulse_on;
      MODE_DIRECT:                        sel = pwm_s;
      MODE_LEVEL:                         sel = 1'b1;
      default:                            sel = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) gate <= 1'b0;
    else     gate <= lane_en && sel;
  end
endmodule

// File: rtl/stagger_dimmer.sv
module stagger_dimmer #(
  parameter int CHANNELS    = 8,
  parameter int PH_W        = 8,
  parameter int FIXED_STEP  = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(CHANNELS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step_tick,
  input  logic [PH_W-1:0]     duty,
  input  logic [2:0]          mode,
  input  logic [CNT_W-1:0]    lane_count,
  input  logic                pwm_in,
  output logic [CHANNELS-1:0] gate,
  output logic [PH_W-1:0]     dc_level
);
  logic [PH_W-1:0]               phase;
  logic                          wrap;
  logic [PH_W-1:0]               duty_q;
  logic [2:0]                    mode_q;
  logic [CNT_W-1:0]              cnt_q;
  logic [CHANNELS-1:0][PH_W-1:0] offsets;
  logic                          pwm_s;

  dim_phase_ctr #(.PH_W(PH_W)) u_ctr (
    .clk(clk), .rst(rst), .step_tick(step_tick), .phase(phase), .wrap(wrap)
  );

  dim_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pwm_in), .dout(pwm_s)
  );

  dim_shadow #(
    .CHANNELS(CHANNELS), .PH_W(PH_W), .CNT_W(CNT_W), .FIXED_STEP(FIXED_STEP)
  ) u_shadow (
    .clk(clk), .rst(rst), .load(wrap),
    .duty_in(duty), .mode_in(mode), .count_in(lane_count),
    .duty_q(duty_q), .mode_q(mode_q), .cnt_q(cnt_q),
    .offsets(offsets), .dc_level(dc_level)
  );

  generate
    for (genvar g = 0; g < CHANNELS; g++) begin : g_lane
      dim_lane #(.PH_W(PH_W)) u_lane (
        .clk(clk), .rst(rst), .phase(phase), .offset(offsets[g]),
        .duty(duty_q), .mode(mode_q), .lane_en(CNT_W'(g) < cnt_q),
        .pwm_s(pwm_s), .gate(gate[g])
      );
    end
  endgenerate
endmodule

// File: rtl/dim_checker.sv
module dim_checker
  import dim_pkg::*;
#(
  parameter int CHANNELS = 8,
  parameter int PH_W     = 8,
  parameter int CNT_W    = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                step_tick,
  input logic [CHANNELS-1:0] gate,
  input logic [PH_W-1:0]     dc_level,
  input logic [PH_W-1:0]     phase,
  input logic                wrap,
  input logic [PH_W-1:0]     duty_q,
  input logic [2:0]          mode_q,
  input logic [CNT_W-1:0]    cnt_q,
  input logic                pwm_s
);
  logic [CHANNELS-1:0] act_mask;

  always_comb begin
    for (int k = 0; k < CHANNELS; k++) act_mask[k] = (k < int'(cnt_q));
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (gate == '0 && dc_level == '1));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
    (step_tick && phase != '1) |=> (phase == $past(phase) + 1'b1));

  assert_hold_setting_R2: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> ($stable(duty_q) && $stable(mode_q) && $stable(cnt_q)));

  assert_zero_duty_dark_R4: assert property (@(posedge clk) disable iff (rst)
    (duty_q == '0 && is_pulse_mode(mode_q)) |=> (gate == '0));

  assert_direct_low_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_DIRECT && !pwm_s) |=> (gate == '0));

  assert_level_all_on_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_LEVEL) |=> (gate == $past(act_mask)));

  assert_lane_limit_R9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((gate & ~$past(act_mask)) == '0));
endmodule

bind stagger_dimmer dim_checker #(
  .CHANNELS(CHANNELS), .PH_W(PH_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .step_tick(step_tick), .gate(gate),
  .dc_level(dc_level), .phase(phase), .wrap(wrap), .duty_q(duty_q),
  .mode_q(mode_q), .cnt_q(cnt_q), .pwm_s(pwm_s)
);

// File: tb/sim_stagger_dimmer.sv
module sim_stagger_dimmer;
  localparam int CH = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          step_tick = 1'b0;
  logic [7:0]    duty = '0;
  logic [2:0]    mode = '0;
  logic [3:0]    lane_count = '0;
  logic          pwm_in = 1'b0;
  logic [CH-1:0] gate;
  logic [7:0]    dc_level;

  int    n_chk = 0, n_fail = 0;
  int    tick_div = 1;
  bit    running = 0, done = 0;
  string tag = "R1 reset";

  stagger_dimmer u0 (
    .clk(clk), .rst(rst), .step_tick(step_tick), .duty(duty), .mode(mode),
    .lane_count(lane_count), .pwm_in(pwm_in), .gate(gate), .dc_level(dc_level)
  );

  always #4 clk = ~clk;

  // reference model state
  int            m_ph, m_duty, m_mode, m_cnt, m_dc;
  int            m_off [CH];
  logic          m_s1, m_s2;
  logic [CH-1:0] m_gate;

  always @(posedge clk) begin
    logic [CH-1:0] g;
    int rel;
    bit on;
    if (rst) begin
      m_ph = 0; m_duty = 0; m_mode = 0; m_cnt = 0; m_dc = 255;
      m_s1 = 0; m_s2 = 0; m_gate = '0;
      for (int k = 0; k < CH; k++) m_off[k] = 0;
    end else begin
      for (int k = 0; k < CH; k++) begin
        rel = (m_ph - m_off[k] + 256) % 256;
        case (m_mode)
          0, 1, 2: on = (m_duty == 255) || (rel < m_duty);
          3:       on = m_s2;
          4:       on = 1;
          default: on = 0;
        endcase
        g[k] = (k < m_cnt) && on;
      end
      m_gate = g;
      m_s2 = m_s1;
      m_s1 = pwm_in;
      if (step_tick && m_ph == 255) begin
        m_ph = 0; m_duty = int'(duty); m_mode = int'(mode);
        m_cnt = (lane_count > 8) ? 8 : int'(lane_count);
        m_dc = (mode == 3'd4) ? int'(duty) : 255;
        for (int k = 0; k < CH; k++) begin
          if (m_mode == 1)                   m_off[k] = (2 * k) % 256;
          else if (m_mode == 2 && m_cnt > 0) m_off[k] = (256 * k) / m_cnt;
          else                               m_off[k] = 0;
        end
      end else if (step_tick) begin
        m_ph = m_ph + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (running && !rst) begin
      n_chk++;
      if (gate !== m_gate || int'(dc_level) != m_dc) begin
        n_fail++;
        $display("FAIL %s: gate=%b dc=%0d expected gate=%b dc=%0d",
                 tag, gate, dc_level, m_gate, m_dc);
      end
    end
  end

  // tick and pwm stimulus, driven on the falling edge
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      step_tick = ((cyc % tick_div) == 0);
      pwm_in    = ((cyc % 37) < 14);
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic run(input int md, input int dt, input int cn, input int per,
                     input int tdiv, input string t);
    @(negedge clk);
    mode = 3'(md); duty = 8'(dt); lane_count = 4'(cn); tick_div = tdiv; tag = t;
    repeat (per * 256 * tdiv + 7) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: run state=hung expected=complete");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    n_chk++;
    if (gate !== '0 || dc_level !== 8'd255) begin
      n_fail++;
      $display("FAIL R1: gate=%b dc=%0d expected gate=0 dc=255", gate, dc_level);
    end
    rst = 1'b0;
    running = 1;
    run(0, 100, 8, 2, 1, "R3 together");
    run(0, 30, 8, 1, 1, "R2 mid-period change");
    run(0, 200, 8, 2, 1, "R2 new value at wrap");
    run(0, 0, 8, 2, 1, "R4 zero duty");
    run(0, 255, 8, 2, 1, "R4 full duty");
    run(1, 60, 8, 2, 1, "R5 fixed step");
    run(1, 250, 8, 2, 1, "R5 fixed wrap");
    run(2, 40, 8, 2, 1, "R6 spread eight");
    run(2, 200, 5, 2, 1, "R6 spread five");
    run(2, 100, 3, 2, 2, "R6 spread three slow tick");
    run(3, 0, 8, 2, 1, "R7 direct");
    run(4, 77, 6, 2, 1, "R8 level");
    run(1, 90, 0, 2, 1, "R9 no lanes");
    run(0, 128, 12, 2, 1, "R9 count clipped");
    run(2, 128, 4, 2, 1, "R9 four lanes");
    run(5, 128, 8, 2, 1, "R10 reserved code");
    run(7, 255, 8, 2, 1, "R10 reserved code");
    finish_up();
  end
endmodule